// File: doc/BRIEF.md
# Sticky-Latch Interrupt Aggregation Controller

This block collects 24 peripheral interrupt inputs into a single interrupt line for a CPU. Each input is turned into an event by a per-source trigger mode: level-high, rising edge, falling edge or both edges. Events set a sticky pending bit, and that bit stays set until software acknowledges it by writing a one to it. An enable mask decides which pending sources reach the CPU. Software can write the mask as a whole, or change single bits through a set alias and a clear alias without a read-modify-write.

An identity register shows the sources that are both pending and enabled. The CPU line is the registered OR of that register. To find the highest active source, software reads the identity register and takes the highest set bit; the hardware does no priority encoding. Register access uses a simple 32-bit bus. A write takes effect at the clock edge on which `bus_en_i` and `bus_we_i` are both high. Read data is combinational from `bus_addr_i`. The source inputs must already be synchronous to `clk_i`.

Top module: `irqagg_ctrl`

## Requirements
- R1: After reset the sticky, enable and both trigger registers read zero and `irq_o` is low.
- R2: A source whose trigger mode {bit in 0x60, bit in 0x5c} is 00 is level-high. Its sticky bit is set on every clock edge at which the input is high, and no event is made while the input is low.
- R3: Mode 01 captures a rising edge, 10 a falling edge and 11 either edge. An edge is a difference between the input and its value one clock earlier, and that earlier value is zero right after reset.
- R4: The sticky register at 0x10 holds each captured bit until a write at 0x10 with a one in that bit position. A write of zero to a bit leaves it unchanged.
- R5: When a new event and a write-one-to-clear hit the same bit on the same edge, the bit stays set.
- R6: The enable register at 0x18 is read/write. Writing 0 masks every source.
- R7: A write at 0x20 sets the enable bits written as one, and a write at 0x1c clears them. Bits written as zero keep their value, and both aliases read as zero.
- R8: The register at 0x38 reads the sticky register ANDed with the enable register and ignores writes.
- R9: `irq_o` equals the OR of the identity bits as they were one clock earlier.
- R10: Bits 31..24 of every register read zero and ignore writes. Trigger registers are at 0x5c (low mode bit) and 0x60 (high mode bit), and any address not listed reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 24 | Peripheral interrupt inputs, synchronous to clk_i |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The bench walks all four trigger modes over all 24 sources. For each one it raises the input, acknowledges while the input is still high, then drops the input. A design with a swapped mode encoding, or one that lost the delayed copy of the input, would latch on the wrong edge or miss the falling edge. The acknowledge that lands while a level source is still high checks that capture wins. A design that let the clear win would show a cleared bit for one cycle.

The alias writes use patterns whose zero bits must survive, so a design that copied the write data into the enable register would fail. Further checks cover the one-cycle lag of `irq_o` behind the identity, identity masking by the enable bits, and zero read-back of the upper bits and of unmapped offsets.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Register offsets; software decodes these, so they are fixed.
    localparam logic [7:0] OFS_STICKY = 8'h10;
    localparam logic [7:0] OFS_EN     = 8'h18;
    localparam logic [7:0] OFS_EN_CLR = 8'h1C;
    localparam logic [7:0] OFS_EN_SET = 8'h20;
    localparam logic [7:0] OFS_IDENT  = 8'h38;
    localparam logic [7:0] OFS_TRIG0  = 8'h5C;
    localparam logic [7:0] OFS_TRIG1  = 8'h60;

    // Mode is {trig1 bit, trig0 bit}
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_mode_e;

    function automatic logic pick_event(input logic [1:0] mode,
                                        input logic now_v,
                                        input logic before_v);
        logic ev;
        case (trig_mode_e'(mode))
            TRIG_LEVEL: ev = now_v;
            TRIG_RISE:  ev = now_v & ~before_v;
            TRIG_FALL:  ev = ~now_v & before_v;
            default:    ev = now_v ^ before_v;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/irqagg_capture.sv
module irqagg_capture
    import irqagg_pkg::*;
#(
    parameter int unsigned NSRC = 24
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] trig0_i,
    input  logic [NSRC-1:0] trig1_i,
    output logic [NSRC-1:0] evt_o
);

    typedef struct packed {
        logic [NSRC-1:0] prev;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = src_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign evt_o[g] = pick_event({trig1_i[g], trig0_i[g]}, src_i[g], cap_q.prev[g]);
    end

    // R3: an input that did not change and is low makes no event in any mode
    no_evt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((src_i == '0) && (cap_q.prev == '0)) |-> (evt_o == '0));

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned NSRC   = 24,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NSRC-1:0]   evt_i,
    output logic [NSRC-1:0]   trig0_o,
    output logic [NSRC-1:0]   trig1_o,
    output logic              irq_o
);

    localparam int unsigned PAD_W = DATA_W - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] sticky;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] trig0;
        logic [NSRC-1:0] trig1;
        logic            irq;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic            wr;
    logic [NSRC-1:0] wmask;
    logic [NSRC-1:0] ack_mask;
    logic [NSRC-1:0] ident;
    logic [NSRC-1:0] rd_val;

    assign wr    = bus_en_i & bus_we_i;
    assign wmask = bus_wdata_i[NSRC-1:0];
    assign ident = st_q.sticky & st_q.en;

    always_comb begin
        st_d     = st_q;
        ack_mask = '0;
        if (wr && (bus_addr_i == ADDR_W'(OFS_STICKY))) begin
            ack_mask = wmask;
        end
        // new capture overrides an acknowledge of the same bit
        st_d.sticky = (st_q.sticky & ~ack_mask) | evt_i;
        if (wr) begin
            case (bus_addr_i)
                ADDR_W'(OFS_EN):     st_d.en    = wmask;
                ADDR_W'(OFS_EN_CLR): st_d.en    = st_q.en & ~wmask;
                ADDR_W'(OFS_EN_SET): st_d.en    = st_q.en | wmask;
                ADDR_W'(OFS_TRIG0):  st_d.trig0 = wmask;
                ADDR_W'(OFS_TRIG1):  st_d.trig1 = wmask;
                default: ;
            endcase
        end
        st_d.irq = |ident;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            ADDR_W'(OFS_STICKY): rd_val = st_q.sticky;
            ADDR_W'(OFS_EN):     rd_val = st_q.en;
            ADDR_W'(OFS_IDENT):  rd_val = ident;
            ADDR_W'(OFS_TRIG0):  rd_val = st_q.trig0;
            ADDR_W'(OFS_TRIG1):  rd_val = st_q.trig1;
            default:             rd_val = '0;
        endcase
    end

    assign bus_rdata_o = {{PAD_W{1'b0}}, rd_val};
    assign trig0_o     = st_q.trig0;
    assign trig1_o     = st_q.trig1;
    assign irq_o       = st_q.irq;

    // R4
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr && (bus_addr_i == ADDR_W'(OFS_STICKY)))
        |=> ((st_q.sticky & $past(st_q.sticky)) == $past(st_q.sticky)));

    // R5
    capture_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((st_q.sticky & $past(evt_i)) == $past(evt_i)));

    // R7
    set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && (bus_addr_i == ADDR_W'(OFS_EN_SET)))
        |=> ((st_q.en & $past(wmask)) == $past(wmask)));

    // R7
    clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && (bus_addr_i == ADDR_W'(OFS_EN_CLR)))
        |=> ((st_q.en & $past(wmask)) == '0));

    // R9
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ident) |=> irq_o);

    // R9
    irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|ident) |=> !irq_o);

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
    import irqagg_pkg::*;
#(
    parameter int unsigned NSRC   = 24,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] trig0;
    logic [NSRC-1:0] trig1;

    irqagg_capture #(
        .NSRC (NSRC)
    ) u_capture (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (src_i),
        .trig0_i (trig0),
        .trig1_i (trig1),
        .evt_o   (evt)
    );

    irqagg_regs #(
        .NSRC   (NSRC),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .evt_i       (evt),
        .trig0_o     (trig0),
        .trig1_o     (trig1),
        .irq_o       (irq_o)
    );

    // R10
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[DATA_W-1:NSRC] == '0);

endmodule

// File: tb/irqagg_ctrl_tb.sv
module irqagg_ctrl_tb;

    localparam int N = 24;
    localparam logic [31:0] MASK = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irqagg_ctrl u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_en_i    (bus_en),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] bit_i;
        logic        ex;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(8'h10, rd); check("R1 sticky", rd, 0);
        bus_rd(8'h18, rd); check("R1 enable", rd, 0);
        bus_rd(8'h5C, rd); check("R1 trig0", rd, 0);
        bus_rd(8'h60, rd); check("R1 trig1", rd, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R6 R7 R10 enable access
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_rd(8'h18, rd); check("R6 R10 enable all", rd, MASK);
        bus_wr(8'h1C, 32'h0000_F0F0);
        bus_rd(8'h18, rd); check("R7 clear alias", rd, 32'h00FF_0F0F);
        bus_wr(8'h20, 32'h0000_F000);
        bus_rd(8'h18, rd); check("R7 set alias", rd, 32'h00FF_FF0F);
        bus_rd(8'h1C, rd); check("R7 clr alias reads zero", rd, 0);
        bus_rd(8'h20, rd); check("R7 set alias reads zero", rd, 0);
        bus_wr(8'h18, 32'h0);
        bus_rd(8'h18, rd); check("R6 mask all", rd, 0);
        bus_wr(8'h5C, 32'hFFFF_FFFF);
        bus_rd(8'h5C, rd); check("R10 trig0 width", rd, MASK);
        bus_wr(8'h5C, 32'h0);
        bus_rd(8'h3C, rd); check("R10 unmapped 0x3c", rd, 0);
        bus_rd(8'h00, rd); check("R10 unmapped 0x00", rd, 0);

        // R8 R9 identity masking with level sources
        bus_wr(8'h18, 32'h000F_0F0F);
        @(negedge clk); src = 24'hA5A5A5;
        @(negedge clk);
        bus_rd(8'h10, rd); check("R2 level capture", rd, 32'h00A5_A5A5);
        bus_rd(8'h38, rd); check("R8 identity", rd, 32'h0005_0505);
        check("R9 irq lags identity", {31'd0, irq}, 0);
        @(negedge clk);
        check("R9 irq high", {31'd0, irq}, 1);
        bus_wr(8'h38, 32'hFFFF_FFFF);
        bus_rd(8'h38, rd); check("R8 identity read-only", rd, 32'h0005_0505);
        bus_wr(8'h18, 32'h0);
        bus_rd(8'h38, rd); check("R8 identity masked", rd, 0);
        check("R9 irq still high one cycle", {31'd0, irq}, 1);
        @(negedge clk);
        check("R9 irq low", {31'd0, irq}, 0);
        src = '0;
        @(negedge clk);
        bus_wr(8'h10, 32'h0000_0000);
        bus_rd(8'h10, rd); check("R4 zero write no effect", rd, 32'h00A5_A5A5);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h10, rd); check("R4 clear all", rd, 0);

        // R2 R3 R4 R5 sweep over every source and mode
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 4; m++) begin
                bit_i = 32'd1 << i;
                bus_wr(8'h5C, m[0] ? bit_i : 32'h0);
                bus_wr(8'h60, m[1] ? bit_i : 32'h0);
                bus_wr(8'h18, bit_i);
                bus_wr(8'h10, 32'hFFFF_FFFF);
                bus_rd(8'h10, rd); check("R4 cleared", rd, 0);

                // raise the input
                src[i] = 1'b1;
                @(negedge clk);
                ex = (m != 2);
                bus_rd(8'h10, rd);
                check((m == 0) ? "R2 level high" : "R3 rise", rd, ex ? bit_i : 0);
                bus_rd(8'h38, rd); check("R8 sweep identity", rd, ex ? bit_i : 0);
                @(negedge clk);
                check("R9 sweep irq", {31'd0, irq}, {31'd0, ex});
                bus_rd(8'h10, rd); check("R4 sticky holds", rd, ex ? bit_i : 0);

                // acknowledge while input still high
                bus_wr(8'h10, bit_i);
                bus_rd(8'h10, rd);
                check("R5 clear vs capture", rd, (m == 0) ? bit_i : 0);

                // drop the input
                src[i] = 1'b0;
                @(negedge clk);
                ex = (m != 1);
                bus_rd(8'h10, rd);
                check("R3 fall", rd, ex ? bit_i : 0);

                bus_wr(8'h10, 32'hFFFF_FFFF);
                bus_rd(8'h10, rd); check("R2 level low no event", rd, 0);
            end
        end

        done = 1'b1;
        report();
    end

endmodule